// File: doc/BRIEF.md
# Strided Scratchpad Transfer Engine

This block is one DMA channel that copies 128-bit quadwords between a small on-chip scratchpad and main memory. The main-memory side follows a stride pattern: the engine moves a run of quadwords to or from consecutive main-memory addresses, then jumps over a gap of unused quadwords, and repeats this until the channel's total count reaches zero. On the scratchpad side the quadwords are always packed back to back.

Software-side logic loads the channel with a control word, a main-memory address, a scratchpad quadword index, a total count and a stride word, all in one load cycle. The engine runs only if the control word asks for a start and selects the strided mode. When the count reaches zero it raises a one-cycle interrupt and drops the start flag. After that the address register points just past the last gap.

Top module: `stride_dma`

## Requirements
- R1: After reset the engine is idle, `irq` is low, neither port is requested, and `ctrl_q`, `madr_q` and `qwc_q` read zero.
- R2: A load starts a run only when control bit 8 is 1 and control bits 3:2 hold the value 2. A load with any other mode value still stores the registers, but it issues no port request and no interrupt, and bit 8 stays as loaded.
- R3: Each quadword moved (both ports requested and both ready in the same cycle) adds 16 to `madr_q`, adds 1 to the scratchpad index and subtracts 1 from `qwc_q`. A loaded main address has its low four bits cleared.
- R4: The stride word holds the run length in bits 23:16 and the gap length in bits 7:0. After each run, `madr_q` jumps a further gap × 16 bytes.
- R5: A run length of zero makes the run as long as the count that remains when the run begins.
- R6: A run ends early when the count reaches zero partway through it. The gap is still added after that last partial run.
- R7: In a cycle where either ready input is low, nothing moves, and `madr_q` and `qwc_q` hold their values.
- R8: When the count is zero, `irq` goes high for exactly one cycle, two cycles after the cycle that moved the last quadword. In that same cycle bit 8 of `ctrl_q` reads 0, the other control bits keep their values, and the engine is idle.
- R9: With control bit 0 set to 1, data goes from main memory to the scratchpad; with bit 0 at 0, it goes from the scratchpad to main memory. Each quadword arrives unchanged, and only the destination port writes.
- R10: A run started with a total count of zero makes no port request. It still raises the interrupt, one cycle after the load.
- R11: The scratchpad index is 10 bits wide (byte address bits 13:4) and wraps from 1023 to 0.
- R12: A load that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load all channel registers (taken only when idle) |
| cfg_ctrl | input | 32 | Control word: bit 0 direction, bits 3:2 mode, bit 8 start |
| cfg_madr | input | 32 | Main-memory byte address |
| cfg_sidx | input | 10 | Scratchpad quadword index |
| cfg_qwc | input | 16 | Total quadword count |
| cfg_stride | input | 32 | Stride word: gap in 7:0, run length in 23:16 |
| ctrl_q | output | 32 | Current control register |
| madr_q | output | 32 | Current main-memory address |
| qwc_q | output | 16 | Remaining quadword count |
| stride_q | output | 32 | Stored stride word |
| busy | output | 1 | Run in progress |
| irq | output | 1 | One-cycle completion pulse |
| spr_req | output | 1 | Scratchpad access request |
| spr_we | output | 1 | Scratchpad write enable |
| spr_idx | output | 10 | Scratchpad quadword index |
| spr_wdata | output | 128 | Scratchpad write data |
| spr_rdata | input | 128 | Scratchpad read data (same cycle) |
| spr_rdy | input | 1 | Scratchpad ready |
| mem_req | output | 1 | Main-memory access request |
| mem_we | output | 1 | Main-memory write enable |
| mem_addr | output | 32 | Main-memory byte address |
| mem_wdata | output | 128 | Main-memory write data |
| mem_rdata | input | 128 | Main-memory read data (same cycle) |
| mem_rdy | input | 1 | Main-memory ready |

## Verification
The assertions check several rules on every cycle:
- each quadword moved steps the count by one and the address by 16, or by 16 plus the gap at the end of a run;
- a stalled or idle cycle leaves the address and the count unchanged;
- the interrupt lasts one cycle and arrives with the start flag already cleared;
- exactly one port writes whenever a transfer is requested.

Only the bench scenarios can show the rest: the complete address sequence and the data that lands in each memory, the zero-run-length fallback, the partial final run, the scratchpad wrap, the ignored mode and the ignored mid-run load, and the exact cycle of the interrupt.

// File: rtl/stride_dma_pkg.sv
package stride_dma_pkg;
  localparam int ADDR_W    = 32;
  localparam int QW_W      = 128;
  localparam int QW_LG     = 4;
  localparam int CTRL_W    = 32;
  localparam int STRIDE_W  = 32;
  localparam int DIR_BIT   = 0;
  localparam int MODE_LSB  = 2;
  localparam int START_BIT = 8;
  localparam logic [1:0] MODE_STRIDE = 2'd2;
  localparam int FLD_W     = 8;
  localparam int GAP_LSB   = 0;
  localparam int RUN_LSB   = 16;

  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_t;

  typedef struct packed {
    logic [FLD_W-1:0] run_len;
    logic [FLD_W-1:0] gap_len;
  } stride_fields_t;
endpackage

// File: rtl/stride_dma_seq.sv
module stride_dma_seq
  import stride_dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             launch,
  input  logic [CNT_W-1:0] qwc_in,
  input  logic [FLD_W-1:0] run_len,
  input  logic             beat,
  output logic             busy,
  output logic [CNT_W-1:0] qwc,
  output logic             xfer_ok,
  output logic             blk_end,
  output logic             done_evt,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // run length actually used for a new run: zero falls back to what is left
  function automatic logic [CNT_W-1:0] run_size(input logic [FLD_W-1:0] len,
                                                input logic [CNT_W-1:0] left);
    return (len == '0) ? left : CNT_W'(len);
  endfunction

  phase_t           ph;
  logic             blk_open;
  logic [CNT_W-1:0] blk_left;
  logic [CNT_W-1:0] cur_left;
  logic             last_in_blk;

  assign busy        = (ph == PH_RUN);
  assign cur_left    = blk_open ? blk_left : run_size(run_len, qwc);
  assign last_in_blk = (cur_left == ONE) || (qwc == ONE);
  assign xfer_ok     = busy && (qwc != '0);
  assign done_evt    = busy && (qwc == '0);
  assign blk_end     = beat && last_in_blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      qwc      <= '0;
      blk_open <= 1'b0;
      blk_left <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= done_evt;
      if (accept) begin
        qwc      <= qwc_in;
        blk_open <= 1'b0;
        if (launch) ph <= PH_RUN;
      end else if (done_evt) begin
        ph       <= PH_IDLE;
        blk_open <= 1'b0;
      end else if (beat) begin
        qwc <= qwc - ONE;
        if (last_in_blk) begin
          blk_open <= 1'b0;
        end else begin
          blk_open <= 1'b1;
          blk_left <= cur_left - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/stride_dma_agen.sv
module stride_dma_agen
  import stride_dma_pkg::*;
#(
  parameter int SPR_IDX_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [ADDR_W-1:0]    madr_in,
  input  logic [SPR_IDX_W-1:0] sidx_in,
  input  logic [FLD_W-1:0]     gap_len,
  input  logic                 beat,
  input  logic                 blk_end,
  output logic [ADDR_W-1:0]    madr,
  output logic [SPR_IDX_W-1:0] sidx
);
  localparam logic [ADDR_W-1:0] QW_BYTES = ADDR_W'(1) << QW_LG;
  localparam logic [ADDR_W-1:0] LOW_MASK = QW_BYTES - ADDR_W'(1);

  // main address after one quadword, plus the gap when the run closes
  function automatic logic [ADDR_W-1:0] step_madr(input logic [ADDR_W-1:0] a,
                                                  input logic              skip,
                                                  input logic [FLD_W-1:0]  gap);
    logic [ADDR_W-1:0] extra;
    extra = skip ? (ADDR_W'(gap) << QW_LG) : '0;
    return a + QW_BYTES + extra;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      madr <= '0;
      sidx <= '0;
    end else if (accept) begin
      madr <= madr_in & ~LOW_MASK;
      sidx <= sidx_in;
    end else if (beat) begin
      madr <= step_madr(madr, blk_end, gap_len);
      sidx <= sidx + SPR_IDX_W'(1);
    end
  end
endmodule

// File: rtl/stride_dma_route.sv
module stride_dma_route
  import stride_dma_pkg::*;
(
  input  logic            dir_to_spr,
  input  logic            xfer_ok,
  input  logic [QW_W-1:0] spr_rdata,
  input  logic [QW_W-1:0] mem_rdata,
  output logic            spr_req,
  output logic            spr_we,
  output logic [QW_W-1:0] spr_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [QW_W-1:0] mem_wdata
);
  assign spr_req   = xfer_ok;
  assign mem_req   = xfer_ok;
  assign spr_we    = xfer_ok && dir_to_spr;
  assign mem_we    = xfer_ok && !dir_to_spr;
  assign spr_wdata = mem_rdata;
  assign mem_wdata = spr_rdata;
endmodule

// File: rtl/stride_dma.sv
module stride_dma
  import stride_dma_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SPR_IDX_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic [CTRL_W-1:0]    cfg_ctrl,
  input  logic [ADDR_W-1:0]    cfg_madr,
  input  logic [SPR_IDX_W-1:0] cfg_sidx,
  input  logic [CNT_W-1:0]     cfg_qwc,
  input  logic [STRIDE_W-1:0]  cfg_stride,
  output logic [CTRL_W-1:0]    ctrl_q,
  output logic [ADDR_W-1:0]    madr_q,
  output logic [CNT_W-1:0]     qwc_q,
  output logic [STRIDE_W-1:0]  stride_q,
  output logic                 busy,
  output logic                 irq,
  output logic                 spr_req,
  output logic                 spr_we,
  output logic [SPR_IDX_W-1:0] spr_idx,
  output logic [QW_W-1:0]      spr_wdata,
  input  logic [QW_W-1:0]      spr_rdata,
  input  logic                 spr_rdy,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [QW_W-1:0]      mem_wdata,
  input  logic [QW_W-1:0]      mem_rdata,
  input  logic                 mem_rdy
);
  logic           accept_w;
  logic           launch_w;
  logic           xfer_ok_w;
  logic           beat_w;
  logic           blk_end_w;
  logic           done_w;
  stride_fields_t fld_w;

  assign accept_w = cfg_load && !busy;
  assign launch_w = accept_w && cfg_ctrl[START_BIT] &&
                    (cfg_ctrl[MODE_LSB +: 2] == MODE_STRIDE);
  assign beat_w   = xfer_ok_w && spr_rdy && mem_rdy;
  assign fld_w    = '{run_len: stride_q[RUN_LSB +: FLD_W],
                      gap_len: stride_q[GAP_LSB +: FLD_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      stride_q <= '0;
    end else if (accept_w) begin
      ctrl_q   <= cfg_ctrl;
      stride_q <= cfg_stride;
    end else if (done_w) begin
      ctrl_q[START_BIT] <= 1'b0;
    end
  end

  stride_dma_seq #(.CNT_W(CNT_W)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept_w),
    .launch   (launch_w),
    .qwc_in   (cfg_qwc),
    .run_len  (fld_w.run_len),
    .beat     (beat_w),
    .busy     (busy),
    .qwc      (qwc_q),
    .xfer_ok  (xfer_ok_w),
    .blk_end  (blk_end_w),
    .done_evt (done_w),
    .irq      (irq)
  );

  stride_dma_agen #(.SPR_IDX_W(SPR_IDX_W)) agen_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept_w),
    .madr_in (cfg_madr),
    .sidx_in (cfg_sidx),
    .gap_len (fld_w.gap_len),
    .beat    (beat_w),
    .blk_end (blk_end_w),
    .madr    (madr_q),
    .sidx    (spr_idx)
  );

  stride_dma_route route_i (
    .dir_to_spr (ctrl_q[DIR_BIT]),
    .xfer_ok    (xfer_ok_w),
    .spr_rdata  (spr_rdata),
    .mem_rdata  (mem_rdata),
    .spr_req    (spr_req),
    .spr_we     (spr_we),
    .spr_wdata  (spr_wdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata)
  );

  assign mem_addr = madr_q;
endmodule

// File: rtl/stride_dma_chk.sv
module stride_dma_chk
  import stride_dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                irq,
  input logic [CTRL_W-1:0]   ctrl_q,
  input logic [ADDR_W-1:0]   madr_q,
  input logic [CNT_W-1:0]    qwc_q,
  input logic [STRIDE_W-1:0] stride_q,
  input logic                spr_req,
  input logic                spr_we,
  input logic                mem_req,
  input logic                mem_we,
  input logic                beat,
  input logic                blk_end
);
  // R2
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!spr_req && !mem_req));

  // R3
  qwc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (qwc_q == $past(qwc_q) - CNT_W'(1)));

  // R3
  madr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !blk_end) |=> (madr_q == $past(madr_q) + 32'd16));

  // R4
  gap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && blk_end) |=>
      (madr_q == $past(madr_q) + 32'd16 + (32'(stride_q[GAP_LSB +: FLD_W]) << 4)));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !beat) |=> ($stable(madr_q) && $stable(qwc_q)));

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R8
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && !ctrl_q[START_BIT]));

  // R9
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spr_req |-> (spr_we != mem_we));

  // R10
  empty_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && qwc_q == '0) |-> !spr_req);
endmodule

bind stride_dma stride_dma_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .irq      (irq),
  .ctrl_q   (ctrl_q),
  .madr_q   (madr_q),
  .qwc_q    (qwc_q),
  .stride_q (stride_q),
  .spr_req  (spr_req),
  .spr_we   (spr_we),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .beat     (beat_w),
  .blk_end  (blk_end_w)
);

// File: tb/stride_dma_tb_top.sv
`timescale 1ns/1ps
module stride_dma_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_load = 1'b0;
  logic [31:0]  cfg_ctrl = '0;
  logic [31:0]  cfg_madr = '0;
  logic [9:0]   cfg_sidx = '0;
  logic [15:0]  cfg_qwc = '0;
  logic [31:0]  cfg_stride = '0;
  logic [31:0]  ctrl_q, madr_q, stride_q, mem_addr;
  logic [15:0]  qwc_q;
  logic         busy, irq, spr_req, spr_we, mem_req, mem_we;
  logic [9:0]   spr_idx;
  logic [127:0] spr_wdata, spr_rdata, mem_wdata, mem_rdata;
  logic         spr_rdy = 1'b1;
  logic         mem_rdy = 1'b1;

  logic [127:0] main_m [0:255];
  logic [127:0] spr_m  [0:1023];
  logic         init_req = 1'b0;
  int           n_chk = 0;
  int           n_fail = 0;
  int           cyc = 0;

  always #10 clk = ~clk;

  stride_dma dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ctrl(cfg_ctrl),
    .cfg_madr(cfg_madr), .cfg_sidx(cfg_sidx), .cfg_qwc(cfg_qwc),
    .cfg_stride(cfg_stride), .ctrl_q(ctrl_q), .madr_q(madr_q), .qwc_q(qwc_q),
    .stride_q(stride_q), .busy(busy), .irq(irq), .spr_req(spr_req),
    .spr_we(spr_we), .spr_idx(spr_idx), .spr_wdata(spr_wdata),
    .spr_rdata(spr_rdata), .spr_rdy(spr_rdy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
  );

  function automatic logic [127:0] pat_main(input int i);
    return {4{32'hA000_0000 | 32'(i)}};
  endfunction
  function automatic logic [127:0] pat_spr(input int i);
    return {4{32'h5000_0000 | 32'(i)}};
  endfunction

  assign mem_rdata = main_m[mem_addr[11:4]];
  assign spr_rdata = spr_m[spr_idx];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (init_req) begin
      for (int i = 0; i < 256; i++)  main_m[i] <= pat_main(i);
      for (int i = 0; i < 1024; i++) spr_m[i]  <= pat_spr(i);
    end else if (spr_req && spr_rdy && mem_rdy) begin
      if (spr_we) spr_m[spr_idx] <= spr_wdata;
      if (mem_we) main_m[mem_addr[11:4]] <= mem_wdata;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <= 150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic init_mem();
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
  endtask

  task automatic do_load(input logic [31:0] c, input logic [31:0] m,
                         input logic [9:0] s, input logic [15:0] q,
                         input logic [31:0] st);
    @(negedge clk);
    cfg_ctrl = c; cfg_madr = m; cfg_sidx = s; cfg_qwc = q; cfg_stride = st;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    chk(!busy && !irq && !spr_req && !mem_req, "R1", "idle outputs",
        {busy, irq, spr_req, mem_req}, 0);
    chk(ctrl_q == 0 && madr_q == 0 && qwc_q == 0, "R1", "register reset",
        {ctrl_q, madr_q}, 0);
  endtask

  task automatic run_case(input string rq, input logic dir, input logic [31:0] m0,
                          input int s0, input int n, input int tq, input int sq,
                          input bit stall);
    logic [31:0] ea [0:63];
    logic [31:0] a, ctl;
    int rem, bs, k, beats, irqs, last_b, irq_t, stalls, bad;
    init_mem();
    a = m0 & 32'hFFFF_FFF0; rem = n; k = 0;
    while (rem > 0) begin
      bs = (tq == 0) ? rem : tq;
      for (int i = 0; i < bs && rem > 0; i++) begin
        ea[k] = a; k++; a += 32'd16; rem--;
      end
      a += 32'(sq * 16);
    end
    ctl = 32'h0000_0148 | 32'(dir);
    do_load(ctl, m0, 10'(s0), 16'(n), 32'h0A00_0A00 | 32'(tq << 16) | 32'(sq));
    beats = 0; irqs = 0; last_b = -1; irq_t = -1; stalls = 0;
    for (int t = 0; t < 4000; t++) begin
      if (stall) begin mem_rdy = (t % 3) != 1; spr_rdy = (t % 4) != 2; end
      else begin mem_rdy = 1'b1; spr_rdy = 1'b1; end
      #1;
      if (irq) begin irqs++; if (irq_t < 0) irq_t = t; end
      if (spr_req && spr_rdy && mem_rdy) begin beats++; last_b = t; end
      else if (spr_req) stalls++;
      @(negedge clk);
      if (irq_t >= 0 && t > irq_t + 2) break;
    end
    mem_rdy = 1'b1; spr_rdy = 1'b1;
    #1;
    // R3 number of quadwords moved and final count
    chk(beats == n && qwc_q == 0, "R3", "beats/count", beats, n);
    chk(madr_q == a, rq, "final main address", madr_q, a);
    // R8 start flag cleared, rest kept
    chk(ctrl_q == (ctl & ~32'h100) && !busy, "R8", "control after done",
        ctrl_q, ctl & ~32'h100);
    chk(irqs == 1, "R8", "irq pulse count", irqs, 1);
    if (n > 0) chk(irq_t == last_b + 2, "R8", "irq cycle", irq_t, last_b + 2);
    else       chk(irq_t == 1 && beats == 0, "R10", "empty run irq cycle", irq_t, 1);
    if (stall) chk(stalls > 0, "R7", "stall cycles seen", stalls, 1);
    bad = 0;
    for (int j = 0; j < n; j++) begin
      if (dir) begin
        if (spr_m[(s0 + j) % 1024] !== pat_main(int'(ea[j][11:4]))) bad++;
      end else begin
        if (main_m[ea[j][11:4]] !== pat_spr((s0 + j) % 1024)) bad++;
      end
    end
    // R9 data placement (R11 when the index wraps)
    chk(bad == 0, (s0 + n > 1024) ? "R11" : "R9", "data mismatches", bad, 0);
  endtask

  task automatic t_wrong_mode();
    int reqs;
    reqs = 0;
    do_load(32'h0000_0105, 32'h40, 10'd3, 16'd4, 32'h0001_0001);
    for (int t = 0; t < 6; t++) begin
      #1; if (spr_req || mem_req || irq) reqs++;
      @(negedge clk);
    end
    #1;
    // R2
    chk(reqs == 0 && !busy, "R2", "no activity in other mode", reqs, 0);
    chk(ctrl_q == 32'h105 && qwc_q == 4, "R2", "registers stored",
        {ctrl_q, 16'(qwc_q)}, {32'h105, 16'd4});
  endtask

  task automatic t_busy_load();
    int irqs;
    irqs = 0;
    init_mem();
    mem_rdy = 1'b0; spr_rdy = 1'b0;
    do_load(32'h0000_0109, 32'h200, 10'd0, 16'd3, 32'h0001_0000);
    @(negedge clk); @(negedge clk);
    #1;
    chk(busy && qwc_q == 3, "R12", "stalled run state", qwc_q, 3);
    do_load(32'h0000_0108, 32'h800, 10'd9, 16'd9, 32'h0003_0003);
    #1;
    // R12
    chk(qwc_q == 3 && madr_q == 32'h200 && ctrl_q == 32'h109, "R12",
        "mid-run load ignored", madr_q, 32'h200);
    mem_rdy = 1'b1; spr_rdy = 1'b1;
    for (int t = 0; t < 20; t++) begin
      #1; if (irq) irqs++;
      @(negedge clk);
    end
    #1;
    chk(irqs == 1 && madr_q == 32'h230, "R12", "run finishes with old settings",
        madr_q, 32'h230);
    chk(spr_m[2] === pat_main(34), "R12", "last quadword", spr_m[2][31:0],
        pat_main(34) & 128'hFFFF_FFFF);
  endtask

  initial begin
    t_reset();
    // R4 runs of 2 with gap 3, ends on a partial run (R6)
    run_case("R4", 1'b0, 32'h100, 5, 7, 2, 3, 1'b0);
    // R5 zero run length: one run of the whole count; low address bits masked (R3)
    run_case("R5", 1'b1, 32'h104, 40, 5, 0, 4, 1'b0);
    // R7 exact multiple of run length with both ports stalling
    run_case("R4", 1'b1, 32'h300, 100, 6, 3, 1, 1'b1);
    // R6 count ends before the first run is full
    run_case("R6", 1'b0, 32'h500, 7, 2, 4, 2, 1'b0);
    // R10 empty run
    run_case("R10", 1'b1, 32'h600, 0, 0, 2, 2, 1'b0);
    // R11 scratchpad index wraps
    run_case("R11", 1'b1, 32'h700, 1022, 4, 1, 1, 1'b0);
    t_wrong_mode();
    t_busy_load();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule